// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit resolves the operand of an accumulator load. On a start pulse it takes a 4-bit mode code, a register selector and an address field. It works out the effective address, reads the operand from a single-port synchronous data memory when the mode needs it, and returns the operand with a one-cycle done pulse. It can read the program counter, an index register and one port of a small register file. The two auto modes step the selected register by one, and that update leaves the unit as a register-file write.

Memory reads return data one cycle after the request. A mode with no memory access finishes one cycle after start. A mode with one access finishes after two cycles. Memory-indirect makes two back-to-back accesses and finishes after three. The pointer read in the first access becomes the address of the second.

Top module: `opfetch`

## Requirements
- R1: Mode code 0 (immediate) returns the address field as the operand and reports effective address 0. It issues no memory request, and done rises one cycle after start.
- R2: Mode code 1 (direct) uses the address field as the effective address. It makes exactly one memory access, and done rises two cycles after start.
- R3: Mode code 2 (indirect) reads memory at the address field to get the effective address, then reads the operand there. It makes exactly two memory accesses on consecutive cycles, and done rises three cycles after start.
- R4: Mode code 7 (relative) uses PC plus the address field as its effective address. Mode code 8 (indexed) uses the index register plus the address field. Both wrap modulo 2^DW, make one access and finish two cycles after start.
- R5: Mode code 3 (register) returns the selected register's value and reports effective address 0. It makes no memory access and finishes one cycle after start.
- R6: Mode code 4 (register indirect) uses the selected register's value as the effective address and makes one access.
- R7: Mode code 5 (autoincrement) uses the register's old value as the effective address. It writes that value plus 1 back to the same register.
- R8: Mode code 6 (autodecrement) takes the register value minus 1 (wrapping), uses it as the effective address and writes it back to the register.
- R9: Codes 9 to 15 set the illegal flag together with done one cycle after start. They give operand 0, make no memory access and write no register.
- R10: A register write happens only for codes 5 and 6, in the same cycle that done is high, and done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch; sampled while not busy |
| mode | input | 4 | Addressing-mode code |
| reg_sel | input | RAW | Register-file selector |
| addr_field | input | DW | Instruction address field |
| pc | input | DW | Program counter value |
| xr | input | DW | Index register value |
| rf_raddr | output | RAW | Register-file read address |
| rf_rdata | input | DW | Register-file read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RAW | Register write address |
| rf_wdata | output | DW | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_rdata | input | DW | Memory read data, valid the cycle after the request |
| busy | output | 1 | A multi-cycle fetch is in progress |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Unused mode code seen |
| ea | output | DW | Effective address of the last fetch |
| operand | output | DW | Operand of the last fetch |

## Verification
The bench targets the order of the auto modes: incrementing before use would load from the wrong address, and decrementing after use would read one word too high. Repeated auto operations on one register expose both errors, and so does a later register-mode read of the written-back value. Indirect mode is checked for two accesses and a three-cycle latency. A design that used the pointer as the operand, or skipped the second read, returns the pointer word. Illegal codes and register-wrap cases catch a stray memory access, a stray write, and a decrement that fails to wrap.

// File: rtl/opfetch.sv
module opfetch #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     mode,
  input  logic [RAW-1:0] reg_sel,
  input  logic [DW-1:0]  addr_field,
  input  logic [DW-1:0]  pc,
  input  logic [DW-1:0]  xr,
  output logic [RAW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RAW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  output logic           mem_req,
  output logic [DW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy,
  output logic           done,
  output logic           illegal,
  output logic [DW-1:0]  ea,
  output logic [DW-1:0]  operand
);
  localparam logic [3:0] M_IMM = 4'd0, M_DIR = 4'd1, M_IND = 4'd2, M_REG = 4'd3,
                         M_RIND = 4'd4, M_AINC = 4'd5, M_ADEC = 4'd6,
                         M_REL = 4'd7, M_IDX = 4'd8;

  typedef enum logic {S_IDLE, S_ACC} state_t;
  state_t state;

  logic          ptr_pend;
  logic          wb_pend;
  logic [DW-1:0] wb_val;
  logic [DW-1:0] ea_c, op_c, wb_c;
  logic          mem_c, wb_en_c, bad_c;
  logic          accept;

  assign accept   = (state == S_IDLE) && start;
  assign busy     = (state != S_IDLE);
  assign rf_raddr = reg_sel;

  always_comb begin
    ea_c    = '0;
    op_c    = '0;
    wb_c    = '0;
    mem_c   = 1'b0;
    wb_en_c = 1'b0;
    bad_c   = 1'b0;
    case (mode)
      M_IMM:  op_c = addr_field;
      M_DIR:  begin ea_c = addr_field;      mem_c = 1'b1; end
      M_IND:  begin ea_c = addr_field;      mem_c = 1'b1; end
      M_REG:  op_c = rf_rdata;
      M_RIND: begin ea_c = rf_rdata;        mem_c = 1'b1; end
      M_AINC: begin
        ea_c = rf_rdata; mem_c = 1'b1;
        wb_c = rf_rdata + 1'b1; wb_en_c = 1'b1;
      end
      M_ADEC: begin
        ea_c = rf_rdata - 1'b1; mem_c = 1'b1;
        wb_c = rf_rdata - 1'b1; wb_en_c = 1'b1;
      end
      M_REL:  begin ea_c = pc + addr_field; mem_c = 1'b1; end
      M_IDX:  begin ea_c = xr + addr_field; mem_c = 1'b1; end
      default: bad_c = 1'b1;
    endcase
  end

  assign mem_req  = (accept && mem_c) || (state == S_ACC && ptr_pend);
  assign mem_addr = (state == S_ACC && ptr_pend) ? mem_rdata : ea_c;
  assign rf_wdata = wb_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr_pend <= 1'b0;
      wb_pend  <= 1'b0;
      wb_val   <= '0;
      rf_waddr <= '0;
      rf_we    <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      ea       <= '0;
      operand  <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          illegal  <= bad_c;
          ea       <= ea_c;
          wb_pend  <= wb_en_c;
          wb_val   <= wb_c;
          rf_waddr <= reg_sel;
          if (mem_c) begin
            state    <= S_ACC;
            ptr_pend <= (mode == M_IND);
          end else begin
            operand <= op_c;
            done    <= 1'b1;
          end
        end
        S_ACC: if (ptr_pend) begin
          ea       <= mem_rdata;
          ptr_pend <= 1'b0;
        end else begin
          operand <= mem_rdata;
          done    <= 1'b1;
          rf_we   <= wb_pend;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!rf_we && !busy));

  // R1
  imm_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == M_IMM) |=> (done && !busy));

  // R3
  second_access_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && busy) |-> $past(mem_req));
endmodule

// File: tb/opfetch_bench.sv
module opfetch_bench;
  localparam int DW = 16;
  localparam int NREG = 8;
  localparam int RAW = $clog2(NREG);

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [3:0] mode = 0;
  logic [RAW-1:0] reg_sel = 0;
  logic [DW-1:0] addr_field = 0, pc = 0, xr = 0;
  logic [RAW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata, mem_addr, ea, operand;
  logic [DW-1:0] mem_rdata = 0;
  logic rf_we, mem_req, busy, done, illegal;

  always #5 clk = ~clk;

  opfetch #(.DW(DW), .NREG(NREG)) u_opfetch (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
    .addr_field(addr_field), .pc(pc), .xr(xr), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .illegal(illegal), .ea(ea), .operand(operand));

  logic [DW-1:0] mem [1024];
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] rf_m [NREG];

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[9:0]];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;
  assign rf_rdata = rf[rf_raddr];

  typedef struct {
    logic [DW-1:0]  ea, op, wd;
    logic           ill, we;
    logic [RAW-1:0] wa;
    int             lat, acc;
    string          tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int cyc = 0, start_cyc = 0, acc_cnt = 0;
  logic got_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_req) acc_cnt++;
    if (done) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(0, "R10", "unexpected done", 1, 0);
      end else begin
        e = q.pop_front();
        chk(operand == e.op, e.tag, "operand", operand, e.op);
        chk(ea == e.ea, e.tag, "ea", ea, e.ea);
        chk(illegal == e.ill, e.tag, "illegal", illegal, e.ill);
        chk((cyc - start_cyc) == e.lat, e.tag, "latency", cyc - start_cyc, e.lat);
        chk(acc_cnt == e.acc, e.tag, "memory accesses", acc_cnt, e.acc);
        chk(rf_we == e.we, e.tag, "rf_we", rf_we, e.we);
        if (e.we) begin
          chk(rf_wdata == e.wd, e.tag, "writeback data", rf_wdata, e.wd);
          chk(rf_waddr == e.wa, e.tag, "writeback reg", rf_waddr, e.wa);
        end
      end
      got_done = 1;
    end else if (rf_we) begin
      chk(0, "R10", "write without done", 1, 0);
    end
  end

  task automatic issue(input logic [3:0] m, input int r, input logic [DW-1:0] a);
    exp_t e;
    e.ea = 0; e.op = 0; e.wd = 0; e.ill = 0; e.we = 0; e.wa = RAW'(r);
    e.lat = 2; e.acc = 1;
    case (m)
      4'd0: begin e.op = a; e.lat = 1; e.acc = 0; e.tag = "R1"; end
      4'd1: begin e.ea = a; e.tag = "R2"; end
      4'd2: begin e.ea = mem[a[9:0]]; e.lat = 3; e.acc = 2; e.tag = "R3"; end
      4'd3: begin e.op = rf_m[r]; e.lat = 1; e.acc = 0; e.tag = "R5"; end
      4'd4: begin e.ea = rf_m[r]; e.tag = "R6"; end
      4'd5: begin e.ea = rf_m[r]; e.we = 1; e.wd = rf_m[r] + 1'b1; rf_m[r] = e.wd; e.tag = "R7"; end
      4'd6: begin e.ea = rf_m[r] - 1'b1; e.we = 1; e.wd = e.ea; rf_m[r] = e.wd; e.tag = "R8"; end
      4'd7: begin e.ea = pc + a; e.tag = "R4"; end
      4'd8: begin e.ea = xr + a; e.tag = "R4"; end
      default: begin e.ill = 1; e.lat = 1; e.acc = 0; e.tag = "R9"; end
    endcase
    if (e.acc != 0) e.op = mem[e.ea[9:0]];
    q.push_back(e);
    @(posedge clk); #1;
    mode = m; reg_sel = RAW'(r); addr_field = a;
    got_done = 0; acc_cnt = 0; start_cyc = cyc; start = 1;
    @(posedge clk); #1;
    start = 0;
    while (!got_done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = DW'(i * 3 + 7);
    mem[500] = 800; mem[800] = 300; mem[700] = 325; mem[600] = 900;
    mem[400] = 700; mem[401] = 708; mem[399] = 450; mem[1023] = 1234;
    for (int i = 0; i < NREG; i++) begin rf[i] = DW'(i * 10); rf_m[i] = DW'(i * 10); end
    rf[1] = 400; rf_m[1] = 400; rf[3] = 0; rf_m[3] = 0;
    rf[6] = 16'hFFFF; rf_m[6] = 16'hFFFF;
    pc = 200; xr = 100;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!done && !busy && !mem_req && !rf_we && !illegal, "R10", "reset state", 0, 0);

    issue(4'd1, 1, 500);   // R2 direct -> 800
    issue(4'd0, 1, 500);   // R1 immediate -> 500
    issue(4'd2, 1, 500);   // R3 indirect -> 300
    issue(4'd7, 1, 500);   // R4 relative -> 325
    issue(4'd8, 1, 500);   // R4 indexed -> 900
    issue(4'd3, 1, 500);   // R5 register -> 400
    issue(4'd4, 1, 500);   // R6 register indirect -> 700
    issue(4'd5, 1, 0);     // R7 ea 400 -> 700, R1=401
    issue(4'd5, 1, 0);     // R7 ea 401 -> 708, R1=402
    issue(4'd6, 1, 0);     // R8 ea 401, R1=401
    issue(4'd6, 1, 0);     // R8 ea 400
    issue(4'd6, 1, 0);     // R8 ea 399 -> 450
    issue(4'd3, 1, 0);     // R5 read back written value 399
    issue(4'd6, 3, 0);     // R8 wrap 0 -> FFFF
    issue(4'd5, 6, 0);     // R7 wrap FFFF -> 0
    issue(4'd3, 3, 0);     // R10 R3 holds FFFF
    issue(4'd3, 6, 0);     // R10 R6 holds 0
    issue(4'd9, 1, 123);   // R9
    issue(4'd15, 2, 77);   // R9
    issue(4'd3, 1, 0);     // R9 no write happened
    pc = 16'hFF00;
    issue(4'd7, 0, 16'h0200); // R4 wraps to 0x0100
    issue(4'd2, 0, 16'h0005);  // R3 generic pointer
    issue(4'd0, 0, 16'hBEEF);  // R1

    repeat (3) @(posedge clk);
    chk(q.size() == 0, "R10", "queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule